// File: doc/BRIEF.md
# Per-Bank Command Hold-Off Calculator

This block tells a DRAM command scheduler how many more cycles a candidate command aimed at one bank has to wait. The wait comes from the last command committed to that same bank. For every bank the block keeps a small record: whether the bank has seen a command since reset, what that command was, and the cycle count at which it was committed. A candidate can be an activate, a precharge, a precharge-all, an auto-refresh or a power-down entry. For each candidate the block picks the timing terms that belong to the recorded command, adds them into a required gap, and subtracts the cycles that have gone by since that command.

The scheduler drives a free-running cycle count. It also drives a candidate, which is a command code and a bank index, and reads back the hold-off value in the same cycle with no register in the path. When a command is actually issued, the scheduler pulses the commit strobe with that command's code and bank. The record then shows it from the next clock edge on. The timing values are static inputs: write and read latency, write recovery, row precharge, read-to-precharge, refresh cycle, burst length and data-rate shift. Spacing between column commands, the rolling activate window and arbitration between requesters all belong to other blocks.

Top module: `bank_cmd_delay`

## Requirements
- R1: After reset, and for any bank with no recorded command, the hold-off output is 0 for every candidate.
- R2: A commit records its code and the `now_cycle` value only in the bank that `commit_bank` selects, and the record is visible from the next clock edge. The codes are NOP=0, ACT=1, PRE=2, PREA=3, REF=4, PDE=5, RD=6, RDA=7, WR=8, WRA=9. A commit of code 0 or of a code above 9 leaves every record unchanged.
- R3: After WR, the required gap for PRE, PREA and PDE is t_wl + write burst + t_wr.
- R4: After WRA, the required gap for ACT, REF and PREA is t_wl + write burst + t_wr + t_rp. For PDE it is t_wl + write burst + t_wr + 1.
- R5: After RD, the required gap for PRE and PREA is t_rtp. After RDA, the required gap for ACT, PREA and REF is t_rtp + t_rp.
- R6: After RD or RDA, the required gap for PDE is t_rl + read burst + 1.
- R7: After REF, every candidate from ACT to PDE has a required gap of t_rfc.
- R8: The read burst is burst_len >> rate_shift. The write burst is burst_len - 1 when rate_shift is 0, which is single data rate, and burst_len >> rate_shift otherwise.
- R9: The hold-off is the required gap minus (now_cycle - recorded cycle) taken modulo 2^CW. The result saturates at 0.
- R10: A candidate code outside 1..5 gives a hold-off of 0. So does any prior/candidate pair not listed in R3 to R7, such as ACT after RD or PRE after WRA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all bank records |
| now_cycle | input | CW | Current cycle count, free running |
| cand_cmd | input | 4 | Code of the candidate command |
| cand_bank | input | BW | Bank the candidate targets |
| commit_en | input | 1 | Strobe: a command is issued this cycle |
| commit_cmd | input | 4 | Code of the issued command |
| commit_bank | input | BW | Bank of the issued command |
| t_wl | input | TW | Write latency in cycles |
| t_rl | input | TW | Read latency in cycles |
| t_wr | input | TW | Write recovery in cycles |
| t_rp | input | TW | Row precharge in cycles |
| t_rtp | input | TW | Read-to-precharge in cycles |
| t_rfc | input | TW | Refresh cycle time in cycles |
| burst_len | input | TW | Burst length in beats, at least 1 |
| rate_shift | input | 2 | log2 of beats per clock; 0 means single data rate |
| delay_out | output | GW | Cycles the candidate must still wait |

## Verification
The bench probes the hold-off one cycle short of the required gap and exactly at it. A design with an off-by-one in the subtraction or in the clamp would report 1 where 0 is due, or 0 one cycle early. At single data rate it checks the write burst against the read burst. A design that divided by the rate there would come out one cycle long after every write. It also checks an elapsed count that wraps past zero, which a design that compares without modular arithmetic would saturate wrongly. Other checks cover commits to one bank leaking into another, ignored commit codes that overwrite a record, and pairs outside the table that pick up a gap they should not have.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_PRE  = 4'd2,
    CMD_PREA = 4'd3,
    CMD_REF  = 4'd4,
    CMD_PDE  = 4'd5,
    CMD_RD   = 4'd6,
    CMD_RDA  = 4'd7,
    CMD_WR   = 4'd8,
    CMD_WRA  = 4'd9
  } dcmd_e;

  // Candidate codes handled by the calculator
  function automatic logic is_candidate(input logic [3:0] c);
    return (c >= 4'(CMD_ACT)) && (c <= 4'(CMD_PDE));
  endfunction

  // Codes that update a bank record on commit
  function automatic logic is_recordable(input logic [3:0] c);
    return (c >= 4'(CMD_ACT)) && (c <= 4'(CMD_WRA));
  endfunction

endpackage

// File: rtl/ddc_rec_table.sv
module ddc_rec_table
  import ddc_pkg::*;
#(
  parameter int BANKS = 8,
  parameter int BW    = $clog2(BANKS),
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_bank,
  input  logic [3:0]    wr_cmd,
  input  logic [CW-1:0] wr_cyc,
  input  logic [BW-1:0] rd_bank,
  output logic          rd_hit,
  output logic [3:0]    rd_cmd,
  output logic [CW-1:0] rd_cyc
);

  logic          hit_v [BANKS];
  logic [3:0]    cmd_v [BANKS];
  logic [CW-1:0] cyc_v [BANKS];

  logic wr_ok;
  assign wr_ok = wr_en && is_recordable(wr_cmd);

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic          hit_q;
    logic [3:0]    cmd_q;
    logic [CW-1:0] cyc_q;
    logic          sel;

    assign sel = wr_ok && (wr_bank == BW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_q <= 1'b0;
        cmd_q <= 4'(CMD_NOP);
        cyc_q <= '0;
      end else if (sel) begin
        hit_q <= 1'b1;
        cmd_q <= wr_cmd;
        cyc_q <= wr_cyc;
      end
    end

    assign hit_v[g] = hit_q;
    assign cmd_v[g] = cmd_q;
    assign cyc_v[g] = cyc_q;
  end

  always_comb begin
    rd_hit = 1'b0;
    rd_cmd = 4'(CMD_NOP);
    rd_cyc = '0;
    for (int i = 0; i < BANKS; i++) begin
      if (rd_bank == BW'(i)) begin
        rd_hit = hit_v[i];
        rd_cmd = cmd_v[i];
        rd_cyc = cyc_v[i];
      end
    end
  end

endmodule

// File: rtl/ddc_gap_calc.sv
module ddc_gap_calc
  import ddc_pkg::*;
#(
  parameter int TW = 8,
  parameter int GW = TW + 3
) (
  input  logic          prior_hit,
  input  logic [3:0]    prior_cmd,
  input  logic [3:0]    cand_cmd,
  input  logic [TW-1:0] t_wl,
  input  logic [TW-1:0] t_rl,
  input  logic [TW-1:0] t_wr,
  input  logic [TW-1:0] t_rp,
  input  logic [TW-1:0] t_rtp,
  input  logic [TW-1:0] t_rfc,
  input  logic [TW-1:0] burst_len,
  input  logic [1:0]    rate_shift,
  output logic [GW-1:0] gap
);

  function automatic logic [GW-1:0] widen(input logic [TW-1:0] v);
    return GW'(v);
  endfunction

  function automatic logic [GW-1:0] rd_burst(input logic [TW-1:0] bl, input logic [1:0] sh);
    return widen(bl) >> sh;
  endfunction

  function automatic logic [GW-1:0] wr_burst(input logic [TW-1:0] bl, input logic [1:0] sh);
    if (sh == 2'd0) return widen(bl) - GW'(1);
    return widen(bl) >> sh;
  endfunction

  logic [GW-1:0] wr_base;   // write latency + burst + recovery
  logic [GW-1:0] rd_pd;     // read latency + burst + 1
  logic [GW-1:0] rd_ap;     // read-to-precharge + row precharge

  assign wr_base = widen(t_wl) + wr_burst(burst_len, rate_shift) + widen(t_wr);
  assign rd_pd   = widen(t_rl) + rd_burst(burst_len, rate_shift) + GW'(1);
  assign rd_ap   = widen(t_rtp) + widen(t_rp);

  logic c_act, c_pre, c_prea, c_ref, c_pde;
  assign c_act  = (cand_cmd == 4'(CMD_ACT));
  assign c_pre  = (cand_cmd == 4'(CMD_PRE));
  assign c_prea = (cand_cmd == 4'(CMD_PREA));
  assign c_ref  = (cand_cmd == 4'(CMD_REF));
  assign c_pde  = (cand_cmd == 4'(CMD_PDE));

  always_comb begin
    gap = '0;
    if (prior_hit && is_candidate(cand_cmd)) begin
      case (prior_cmd)
        4'(CMD_WR): begin
          if (c_pre || c_prea || c_pde) gap = wr_base;
        end
        4'(CMD_WRA): begin
          if (c_act || c_ref || c_prea) gap = wr_base + widen(t_rp);
          else if (c_pde)               gap = wr_base + GW'(1);
        end
        4'(CMD_RD): begin
          if (c_pre || c_prea) gap = widen(t_rtp);
          else if (c_pde)      gap = rd_pd;
        end
        4'(CMD_RDA): begin
          if (c_act || c_prea || c_ref) gap = rd_ap;
          else if (c_pde)               gap = rd_pd;
        end
        4'(CMD_REF): gap = widen(t_rfc);
        default:     gap = '0;
      endcase
    end
  end

endmodule

// File: rtl/ddc_slack.sv
module ddc_slack #(
  parameter int CW = 16,
  parameter int GW = 11
) (
  input  logic [GW-1:0] gap,
  input  logic [CW-1:0] now_cycle,
  input  logic [CW-1:0] last_cycle,
  output logic [GW-1:0] delay
);

  // Modular distance, then saturating subtraction
  function automatic logic [GW-1:0] remaining(input logic [GW-1:0] g,
                                              input logic [CW-1:0] el);
    logic [CW-1:0] g_ext;
    g_ext = CW'(g);
    if (el >= g_ext) return '0;
    return GW'(g_ext - el);
  endfunction

  logic [CW-1:0] elapsed;
  assign elapsed = now_cycle - last_cycle;
  assign delay   = remaining(gap, elapsed);

endmodule

// File: rtl/bank_cmd_delay.sv
module bank_cmd_delay
  import ddc_pkg::*;
#(
  parameter int BANKS = 8,
  parameter int BW    = $clog2(BANKS),
  parameter int CW    = 16,
  parameter int TW    = 8,
  parameter int GW    = TW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] now_cycle,
  input  logic [3:0]    cand_cmd,
  input  logic [BW-1:0] cand_bank,
  input  logic          commit_en,
  input  logic [3:0]    commit_cmd,
  input  logic [BW-1:0] commit_bank,
  input  logic [TW-1:0] t_wl,
  input  logic [TW-1:0] t_rl,
  input  logic [TW-1:0] t_wr,
  input  logic [TW-1:0] t_rp,
  input  logic [TW-1:0] t_rtp,
  input  logic [TW-1:0] t_rfc,
  input  logic [TW-1:0] burst_len,
  input  logic [1:0]    rate_shift,
  output logic [GW-1:0] delay_out
);

  logic          rec_hit;
  logic [3:0]    rec_cmd;
  logic [CW-1:0] rec_cyc;
  logic [GW-1:0] gap_req;

  ddc_rec_table #(.BANKS(BANKS), .BW(BW), .CW(CW)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (commit_en),
    .wr_bank (commit_bank),
    .wr_cmd  (commit_cmd),
    .wr_cyc  (now_cycle),
    .rd_bank (cand_bank),
    .rd_hit  (rec_hit),
    .rd_cmd  (rec_cmd),
    .rd_cyc  (rec_cyc)
  );

  ddc_gap_calc #(.TW(TW), .GW(GW)) u_gap (
    .prior_hit  (rec_hit),
    .prior_cmd  (rec_cmd),
    .cand_cmd   (cand_cmd),
    .t_wl       (t_wl),
    .t_rl       (t_rl),
    .t_wr       (t_wr),
    .t_rp       (t_rp),
    .t_rtp      (t_rtp),
    .t_rfc      (t_rfc),
    .burst_len  (burst_len),
    .rate_shift (rate_shift),
    .gap        (gap_req)
  );

  ddc_slack #(.CW(CW), .GW(GW)) u_slack (
    .gap        (gap_req),
    .now_cycle  (now_cycle),
    .last_cycle (rec_cyc),
    .delay      (delay_out)
  );

endmodule

// File: rtl/bank_cmd_delay_chk.sv
module bank_cmd_delay_chk #(
  parameter int CW = 16,
  parameter int BW = 3,
  parameter int TW = 8,
  parameter int GW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] now_cycle,
  input logic [3:0]    cand_cmd,
  input logic [BW-1:0] cand_bank,
  input logic          commit_en,
  input logic [3:0]    commit_cmd,
  input logic [BW-1:0] commit_bank,
  input logic [TW-1:0] t_rfc,
  input logic          rec_hit,
  input logic [GW-1:0] gap_req,
  input logic [GW-1:0] delay_out
);

  logic cand_ok;
  assign cand_ok = (cand_cmd >= 4'd1) && (cand_cmd <= 4'd5);

  assert_no_record_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_hit |-> delay_out == '0);

  assert_within_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    delay_out <= gap_req);

  assert_countdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(commit_en) && $stable(cand_cmd) && $stable(cand_bank) && $stable(gap_req)
     && now_cycle == CW'($past(now_cycle) + 1'b1))
    |-> delay_out == (($past(delay_out) == '0) ? '0 : GW'($past(delay_out) - 1'b1)));

  assert_refresh_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(commit_en) && $past(commit_cmd) == 4'd4 && cand_bank == $past(commit_bank)
     && cand_ok && $stable(t_rfc) && t_rfc != '0
     && now_cycle == CW'($past(now_cycle) + 1'b1))
    |-> delay_out == GW'(GW'(t_rfc) - GW'(1)));

  assert_unsupported_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cand_ok |-> delay_out == '0);

endmodule

bind bank_cmd_delay bank_cmd_delay_chk #(.CW(CW), .BW(BW), .TW(TW), .GW(GW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .now_cycle   (now_cycle),
  .cand_cmd    (cand_cmd),
  .cand_bank   (cand_bank),
  .commit_en   (commit_en),
  .commit_cmd  (commit_cmd),
  .commit_bank (commit_bank),
  .t_rfc       (t_rfc),
  .rec_hit     (rec_hit),
  .gap_req     (gap_req),
  .delay_out   (delay_out)
);

// File: tb/bank_cmd_delay_test.sv
`timescale 1ns/1ps
module bank_cmd_delay_test;

  localparam int BANKS = 8;
  localparam int BW    = 3;
  localparam int CW    = 16;
  localparam int TW    = 8;
  localparam int GW    = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] now_cycle = '0;
  logic [3:0]    cand_cmd = '0;
  logic [BW-1:0] cand_bank = '0;
  logic          commit_en = 1'b0;
  logic [3:0]    commit_cmd = '0;
  logic [BW-1:0] commit_bank = '0;
  logic [TW-1:0] t_wl = 8'd5, t_rl = 8'd7, t_wr = 8'd6, t_rp = 8'd4;
  logic [TW-1:0] t_rtp = 8'd3, t_rfc = 8'd40, burst_len = 8'd8;
  logic [1:0]    rate_shift = 2'd1;
  logic [GW-1:0] delay_out;

  bank_cmd_delay #(.BANKS(BANKS), .CW(CW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .now_cycle(now_cycle),
    .cand_cmd(cand_cmd), .cand_bank(cand_bank),
    .commit_en(commit_en), .commit_cmd(commit_cmd), .commit_bank(commit_bank),
    .t_wl(t_wl), .t_rl(t_rl), .t_wr(t_wr), .t_rp(t_rp), .t_rtp(t_rtp),
    .t_rfc(t_rfc), .burst_len(burst_len), .rate_shift(rate_shift),
    .delay_out(delay_out)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench model of the bank records
  bit m_valid [BANKS];
  int m_cmd   [BANKS];
  int m_cyc   [BANKS];

  function automatic void model_clear();
    for (int i = 0; i < BANKS; i++) begin
      m_valid[i] = 0; m_cmd[i] = 0; m_cyc[i] = 0;
    end
  endfunction

  function automatic int bench_gap(int prior, int cand);
    int div, rb, wb, wbase;
    div   = 1 << rate_shift;
    rb    = int'(burst_len) / div;
    wb    = (rate_shift == 0) ? int'(burst_len) - 1 : int'(burst_len) / div;
    wbase = int'(t_wl) + wb + int'(t_wr);
    if (cand < 1 || cand > 5) return 0;
    if (prior == 4) return int'(t_rfc);
    case (cand)
      5: case (prior)
           6, 7: return int'(t_rl) + rb + 1;
           8:    return wbase;
           9:    return wbase + 1;
           default: return 0;
         endcase
      2: case (prior)
           6: return int'(t_rtp);
           8: return wbase;
           default: return 0;
         endcase
      3: case (prior)
           6: return int'(t_rtp);
           7: return int'(t_rtp) + int'(t_rp);
           8: return wbase;
           9: return wbase + int'(t_rp);
           default: return 0;
         endcase
      default: case (prior)   // ACT or REF candidate
           7: return int'(t_rtp) + int'(t_rp);
           9: return wbase + int'(t_rp);
           default: return 0;
         endcase
    endcase
  endfunction

  function automatic int bench_delay(int bank, int cand, int now);
    int g, el;
    if (!m_valid[bank]) return 0;
    g  = bench_gap(m_cmd[bank], cand);
    el = (now - m_cyc[bank]) & 16'hFFFF;
    return (g > el) ? g - el : 0;
  endfunction

  task automatic check_val(string tag, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_commit(int bank, int cmd, int cyc);
    @(negedge clk);
    commit_en   = 1'b1;
    commit_bank = BW'(bank);
    commit_cmd  = 4'(cmd);
    now_cycle   = CW'(cyc);
    @(posedge clk);
    if (cmd >= 1 && cmd <= 9) begin
      m_valid[bank] = 1; m_cmd[bank] = cmd; m_cyc[bank] = cyc & 16'hFFFF;
    end
    #1 commit_en = 1'b0;
  endtask

  // probe against a hand-computed value
  task automatic probe_hand(int bank, int cmd, int cyc, int exp, string tag);
    @(negedge clk);
    cand_bank = BW'(bank); cand_cmd = 4'(cmd); now_cycle = CW'(cyc);
    #1 check_val(tag, int'(delay_out), exp);
  endtask

  // probe against the bench model
  task automatic probe_model(int bank, int cmd, int cyc, string tag);
    @(negedge clk);
    cand_bank = BW'(bank); cand_cmd = 4'(cmd); now_cycle = CW'(cyc);
    #1 check_val(tag, int'(delay_out), bench_delay(bank, cmd, cyc));
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    void'($urandom(32'd4711));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty records give zero
    for (int b = 0; b < BANKS; b++) probe_hand(b, 5, 10, 0, "R1 reset state");

    // R3 with double rate: WL5 + BL8>>1 + WR6 = 15
    do_commit(1, 8, 100);
    probe_hand(1, 2, 101, 14, "R3 PRE after WR");
    probe_hand(1, 2, 114, 1,  "R3 one short of gap");
    probe_hand(1, 2, 115, 0,  "R3 at gap");
    probe_hand(1, 1, 101, 0,  "R10 ACT after WR");
    probe_hand(0, 2, 101, 0,  "R2 other bank untouched");
    probe_hand(1, 12, 101, 0, "R10 unsupported candidate");

    // R2: ignored commit codes keep the record
    do_commit(1, 0, 102);
    do_commit(1, 13, 103);
    probe_hand(1, 5, 105, 10, "R2 ignored codes");

    // R4: WRA; ACT gap 15+4=19, PDE 16
    do_commit(2, 9, 200);
    probe_hand(2, 1, 200, 19, "R4 ACT after WRA");
    probe_hand(2, 5, 201, 15, "R4 PDE after WRA");
    probe_hand(2, 2, 201, 0,  "R10 PRE after WRA");

    // R5 / R6 reads: RTP 3, RP 4, RL7 + 4 + 1 = 12
    do_commit(3, 6, 300);
    probe_hand(3, 3, 301, 2,  "R5 PREA after RD");
    probe_hand(3, 5, 300, 12, "R6 PDE after RD");
    do_commit(4, 7, 300);
    probe_hand(4, 4, 302, 5,  "R5 REF after RDA");
    probe_hand(4, 5, 302, 10, "R6 PDE after RDA");

    // R7 refresh
    do_commit(5, 4, 400);
    probe_hand(5, 1, 401, 39, "R7 ACT after REF");
    probe_hand(5, 5, 440, 0,  "R7 at tRFC");

    // R8 single data rate: write burst 7, read burst 8
    rate_shift = 2'd0;
    probe_hand(1, 5, 100, 18, "R8 SDR write burst");
    probe_hand(3, 5, 300, 16, "R8 SDR read burst");
    rate_shift = 2'd2;
    probe_hand(1, 5, 100, 13, "R8 quad rate write burst");
    rate_shift = 2'd1;

    // R9 wraparound of the cycle counter
    do_commit(6, 8, 65530);
    probe_hand(6, 2, 4, 5, "R9 elapsed across wrap");

    // R1 mid-run reset clears records
    pulse_reset();
    probe_hand(5, 1, 401, 0, "R1 reset clears REF record");
    probe_hand(6, 2, 4, 0,   "R1 reset clears WR record");

    // random phase
    cyc = 1000;
    for (int it = 0; it < 3000; it++) begin
      int b, c;
      if (it % 500 == 0) begin
        t_wl = 8'($urandom_range(1, 20)); t_rl = 8'($urandom_range(1, 20));
        t_wr = 8'($urandom_range(1, 20)); t_rp = 8'($urandom_range(1, 20));
        t_rtp = 8'($urandom_range(1, 20)); t_rfc = 8'($urandom_range(1, 200));
        burst_len = 8'(4 << $urandom_range(0, 2));
        rate_shift = 2'($urandom_range(0, 2));
      end
      b = $urandom_range(0, BANKS - 1);
      c = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 15) : $urandom_range(1, 5);
      probe_model(b, c, cyc, "R3-R10 random");
      if ($urandom_range(0, 1) == 1)
        do_commit($urandom_range(0, BANKS - 1), $urandom_range(0, 11), cyc);
      cyc = cyc + $urandom_range(1, 12);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule